// File: doc/BRIEF.md
# Infrared Port Status Register

This block is a single-address, memory-mapped register that the host handheld CPU uses to drive and sense an infrared link. A write keeps three control bits: the lowest bit switches the host's own IR LED, and the top two bits together arm reception. The stored LED bit also leaves the block as a level that other logic can use.

A read builds a status byte from three parts. Constant ones fill the middle bits. The stored control bits are returned as written. One bit reports sensed light, and it is gated by the two arming bits. Light counts as present when any of three sources is high: the external receiver, the host's own LED, or the LED on the cartridge. The host therefore sees its own transmission and the cartridge's as received light. When the colour-mode input is low, the register is not present and every read returns all ones. The read path is combinational.

Top module: `ir_port_reg`

## Requirements
- R1: After reset the stored control bits (7, 6 and 0) are all zero, so a colour-mode read returns 0x3C and `led_out` is low.
- R2: A read while `color_mode` is low returns 0xFF, regardless of the stored bits and the light inputs.
- R3: A colour-mode read returns stored bits 7, 6 and 0 in their own positions, with bits 5 to 2 always one.
- R4: A write with `wr_en` high stores only `wr_data` bits 7, 6 and 0 at the next rising clock edge; the other bits of `wr_data` have no effect on any later read.
- R5: Read bit 1 is one only when stored bits 7 and 6 are both one and light is present; otherwise it is zero.
- R6: Light is present when `ext_ir`, stored bit 0 or `cart_led` is high.
- R7: `led_out` always equals stored bit 0, and it changes only in the cycle after a write.
- R8: A change on `ext_ir`, `cart_led` or `color_mode` appears on `rd_data` in the same cycle, without waiting for a clock edge.
- R9: While `rd_en` is low, `rd_data` is 0x00.
- R10: With `wr_en` low, a value on `wr_data` leaves the stored bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe; the register is loaded at the next rising edge |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Composed status byte; 0x00 when `rd_en` is low |
| color_mode | input | 1 | High when colour mode is active; low makes every read 0xFF |
| ext_ir | input | 1 | Level from the external IR receiver |
| cart_led | input | 1 | Level of the cartridge IR LED |
| led_out | output | 1 | Host IR LED level (stored bit 0) |

## Verification
The bench builds the block with its default absent-register value of 0xFF. With that value, the monochrome reads of R2 are checked against the all-ones pattern. Random write bytes with random junk in bits 5 to 1 exercise the masking of R4, and random light levels from all three sources drive the gated detect bit through every combination of arming bits and light. Directed steps cover the reset value, writes with the strobe low, and light inputs that change between clock edges so that the same-cycle visibility of R8 is checked.

// File: rtl/ir_port_reg.sv
module ir_port_reg #(
  parameter logic [7:0] IDLE_VALUE = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic       color_mode,
  input  logic       ext_ir,
  input  logic       cart_led,
  output logic       led_out
);
  localparam logic [7:0] KEEP_MASK = 8'hC1;
  localparam logic [7:0] FILL_ONES = 8'h3C;

  logic [7:0] ctrl_q;
  logic       light;
  logic       armed;
  logic [7:0] status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wr_data & KEEP_MASK;
  end

  assign led_out = ctrl_q[0];
  assign light   = ext_ir | ctrl_q[0] | cart_led;
  assign armed   = &ctrl_q[7:6];
  assign status  = (ctrl_q & KEEP_MASK) | FILL_ONES | {6'b0, armed & light, 1'b0};
  assign rd_data = !rd_en ? 8'h00 : (color_mode ? status : IDLE_VALUE);

  a_r1_reset_dark: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !led_out);
  a_r2_mono_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !color_mode) |-> rd_data == IDLE_VALUE);
  a_r3_fill_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && color_mode) |-> rd_data[5:2] == 4'hF);
  a_r5_no_light_no_detect: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && color_mode && !ext_ir && !cart_led && !led_out) |-> !rd_data[1]);
  a_r7_led_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> led_out == $past(wr_data[0]));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(led_out));
  a_r9_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == 8'h00);
endmodule

// File: tb/sim_ir_port_reg.sv
module sim_ir_port_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [7:0] rd_data;
  logic color_mode = 1'b1;
  logic ext_ir = 1'b0;
  logic cart_led = 1'b0;
  logic led_out;

  int checks = 0;
  int fails = 0;
  logic [7:0] model = '0;
  bit done = 0;

  always #10 clk = ~clk;

  ir_port_reg u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .color_mode(color_mode),
    .ext_ir(ext_ir), .cart_led(cart_led), .led_out(led_out)
  );

  function automatic logic [7:0] exp_read(logic [7:0] st, logic cm, logic ex,
                                          logic ca, logic rd);
    logic lit;
    if (!rd) return 8'h00;
    if (!cm) return 8'hFF;
    lit = ex | st[0] | ca;
    return (st & 8'hC1) | 8'h3C | {6'b0, st[7] & st[6] & lit, 1'b0};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step(logic we, logic [7:0] wd, logic re, logic cm,
                      logic ex, logic ca, string req);
    @(negedge clk);
    wr_en = we; wr_data = wd; rd_en = re; color_mode = cm;
    ext_ir = ex; cart_led = ca;
    #2;
    check(req, rd_data, exp_read(model, cm, ex, ca, re));
    check("R7", {7'b0, led_out}, {7'b0, model[0]});
    @(posedge clk);
    #1;
    if (we) model = wd & 8'hC1;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(posedge clk);
    #1;
    rd_en = 1'b1;
    #1;
    check("R1", rd_data, 8'h3C);
    check("R1", {7'b0, led_out}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    step(1'b0, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, "R10");
    step(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, "R10");
    step(1'b1, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, "R4");
    step(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, "R4");
    step(1'b1, 8'hC0, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
    step(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, "R5");
    step(1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, "R6");
    step(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, "R6");
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, "R2");
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, "R9");
    step(1'b1, 8'h81, 1'b1, 1'b1, 1'b0, 1'b0, "R3");
    step(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, "R5");

    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1; color_mode = 1'b1;
    wr_data = 8'hC0;
    wr_en = 1'b1;
    @(posedge clk); #1;
    model = 8'hC0;
    wr_en = 1'b0;
    ext_ir = 1'b0; cart_led = 1'b0;
    #2;
    check("R8", rd_data, 8'hFC);
    ext_ir = 1'b1;
    #1;
    check("R8", rd_data, 8'hFE);
    ext_ir = 1'b0; cart_led = 1'b1;
    #1;
    check("R8", rd_data, 8'hFE);
    color_mode = 1'b0;
    #1;
    check("R8", rd_data, 8'hFF);

    for (int i = 0; i < 400; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      step(1'($urandom), d, ($urandom % 8) != 0, ($urandom % 6) != 0,
           1'($urandom), 1'($urandom), "R3");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule